// File: doc/BRIEF.md
# Pulse Width Capture Timer

This block measures how long a signal stays in a state, or how far apart its edges are. A bus write arms it, and it then watches a measurement input that is already synchronized to the clock. The first qualifying start edge opens a measurement window. While the window is open, every pulse on the tick input advances a 16-bit counter. The qualifying end edge closes the window: the count is copied into a read-only result buffer and the completion flag is raised.

A mode bit chooses between two behaviours after a result. In single-shot mode the timer stops and goes idle. In repeat mode it rearms and measures again. Two interrupt lines carry a counter-wrap condition and a measurement-complete condition, and each is gated by its own enable bit. The tick input comes from a prescaler outside the block. The block defines how a rearm write behaves when it lands in the same cycle as a start edge or an end edge.

Top module: `pwc_timer`

## Requirements
- R1: After reset the timer is idle, and reads of all four addresses return 0: control (address 0), status (address 1), result (address 2) and live counter (address 3). Both interrupt lines are low.
- R2: A write to control with bit 0 = 1 clears the live counter to 0 and arms the timer to wait for a start edge. Control bit 0 reads 1 whenever the timer is not idle.
- R3: Control bits [4:2] select the edges. 1 measures rise to fall, 2 measures rise to rise, 3 measures fall to fall, 4 measures fall to rise and 5 measures any edge to the next edge. 0, 6 and 7 never start a measurement.
- R4: The counter counts only in the counting state. It advances once per tick in each cycle after the start-edge cycle and before the end-edge cycle. It holds while the timer waits or is idle.
- R5: On an end edge the counter value is copied to the result buffer and status bit 2 is set. In single-shot mode (control bit 1 = 0) the timer then goes idle.
- R6: In repeat mode (control bit 1 = 1), after an end edge the timer waits for the next start edge. If the end edge is also a start edge, it resumes counting from 0 in that same cycle.
- R7: A counter wrap from 0xFFFF to 0x0000 while counting sets status bit 0, and counting continues.
- R8: irq_ovf equals status bit 0 AND status bit 4. irq_end equals status bit 2 AND status bit 6.
- R9: Writing 0 to status bit 0 or bit 2 clears that flag, and writing 1 leaves it unchanged. A flag set in the same cycle as its clear stays set.
- R10: The result buffer ignores bus writes. It changes only on a measurement end.
- R11: In repeat mode, a rearm write in the same cycle as a start edge puts the timer straight into counting with the counter at 1.
- R12: A rearm write in the same cycle as an end edge sets status bit 2 and returns the timer to waiting with the counter at 0. The result buffer takes the count only in repeat mode.
- R13: A write to control with bit 0 = 0 makes the timer idle and leaves the counter holding its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 2 | Register address |
| wdata | input | CW | Bus write data |
| rdata | output | CW | Bus read data for addr |
| tick | input | 1 | Count-enable pulse from prescaler |
| meas_in | input | 1 | Synchronized measurement input |
| irq_ovf | output | 1 | Counter wrap interrupt |
| irq_end | output | 1 | Measurement complete interrupt |

## Verification
Two pairs of actions can land in the same cycle. A rearm write can coincide with an edge on the measurement input, and a software flag clear can coincide with a hardware flag set. The bench provokes each pair by driving the input level change and the bus write on the same falling clock edge, so that both are sampled by the same rising edge. It then judges the outcome through the bus alone: the status flags, the result buffer, the live counter and the run bit. It compares the readback with what R9, R11 and R12 predict for single-shot and for repeat mode.

// File: rtl/pwc_pkg.sv
// Shared types and register layout for the pulse width capture timer.
package pwc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_COUNT = 2'd2
    } pwc_state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_BUF  = 2'd2;
    localparam logic [1:0] A_CNT  = 2'd3;

    localparam int CTL_RUN  = 0;
    localparam int CTL_CONT = 1;
    localparam int CTL_ES   = 2;
    localparam int ES_W     = 3;

    localparam int SB_OVF    = 0;
    localparam int SB_END    = 2;
    localparam int SB_OVF_IE = 4;
    localparam int SB_END_IE = 6;

    localparam logic [ES_W-1:0] ES_HIGH = 3'd1;
    localparam logic [ES_W-1:0] ES_RISE = 3'd2;
    localparam logic [ES_W-1:0] ES_FALL = 3'd3;
    localparam logic [ES_W-1:0] ES_LOW  = 3'd4;
    localparam logic [ES_W-1:0] ES_ANY  = 3'd5;
endpackage

// File: rtl/pwc_edge.sv
// Edge qualifier: turns the measurement input into start and end events.
// Assumes meas_in is already synchronized to clk.
module pwc_edge
    import pwc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            meas_in,
    input  logic [ES_W-1:0] esel,
    output logic            start_ev,
    output logic            end_ev
);
    logic prev_q;
    logic rise, fall;

    // Remember last input level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= meas_in;
    end

    assign rise = meas_in & ~prev_q;
    assign fall = ~meas_in & prev_q;

    // Map the edge-select code to window-open and window-close events.
    always_comb begin
        start_ev = 1'b0;
        end_ev   = 1'b0;
        case (esel)
            ES_HIGH: begin start_ev = rise;        end_ev = fall;        end
            ES_RISE: begin start_ev = rise;        end_ev = rise;        end
            ES_FALL: begin start_ev = fall;        end_ev = fall;        end
            ES_LOW:  begin start_ev = fall;        end_ev = rise;        end
            ES_ANY:  begin start_ev = rise | fall; end_ev = rise | fall; end
            default: begin start_ev = 1'b0;        end_ev = 1'b0;        end
        endcase
    end
endmodule

// File: rtl/pwc_core.sv
// Measurement sequencer and counter. Decides state, counter and the
// one-cycle set/load strobes for the register block.
// Assumes restart and stop are never high together.
module pwc_core
    import pwc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start_ev,
    input  logic          end_ev,
    input  logic          restart,
    input  logic          stop,
    input  logic          cont,
    output pwc_state_e    state_q,
    output logic [CW-1:0] cnt_q,
    output logic          ovf_set,
    output logic          end_set,
    output logic          buf_ld
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    pwc_state_e    state_d;
    logic [CW-1:0] cnt_d;

    // Next state, next count and event strobes, restart/stop first.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ovf_set = 1'b0;
        end_set = 1'b0;
        buf_ld  = 1'b0;
        if (stop) begin
            state_d = ST_IDLE;
        end else if (restart) begin
            if (state_q == ST_COUNT && end_ev) begin
                end_set = 1'b1;
                buf_ld  = cont;
            end
            if (cont && start_ev) begin
                state_d = ST_COUNT;
                cnt_d   = CNT_ONE;
            end else begin
                state_d = ST_WAIT;
                cnt_d   = '0;
            end
        end else begin
            case (state_q)
                ST_WAIT: begin
                    if (start_ev) begin
                        state_d = ST_COUNT;
                        cnt_d   = '0;
                    end
                end
                ST_COUNT: begin
                    if (end_ev) begin
                        end_set = 1'b1;
                        buf_ld  = 1'b1;
                        if (cont && start_ev) begin
                            cnt_d = '0;
                        end else begin
                            state_d = cont ? ST_WAIT : ST_IDLE;
                        end
                    end else if (tick) begin
                        cnt_d   = cnt_q + CNT_ONE;
                        ovf_set = (cnt_q == CNT_MAX);
                    end
                end
                default: ;
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end
endmodule

// File: rtl/pwc_regs.sv
// Bus register block: control, status flags with enables, result buffer,
// read mux and interrupt gating. A control write takes effect on the mode
// and edge select in the same cycle it arrives.
module pwc_regs
    import pwc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [CW-1:0]   wdata,
    input  pwc_state_e      state,
    input  logic [CW-1:0]   cnt,
    input  logic            ovf_set,
    input  logic            end_set,
    input  logic            buf_ld,
    output logic            restart,
    output logic            stop,
    output logic            cont,
    output logic [ES_W-1:0] esel,
    output logic [CW-1:0]   rdata,
    output logic [CW-1:0]   buf_q,
    output logic            ovf_fl,
    output logic            end_fl,
    output logic            irq_ovf,
    output logic            irq_end
);
    logic            cont_q;
    logic [ES_W-1:0] esel_q;
    logic            ovf_ie, end_ie;
    logic            wr_ctl, wr_st;

    assign wr_ctl  = wr_en && (addr == A_CTRL);
    assign wr_st   = wr_en && (addr == A_STAT);
    assign restart = wr_ctl && wdata[CTL_RUN];
    assign stop    = wr_ctl && !wdata[CTL_RUN];
    assign cont    = wr_ctl ? wdata[CTL_CONT] : cont_q;
    assign esel    = wr_ctl ? wdata[CTL_ES +: ES_W] : esel_q;

    // Control fields are captured on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cont_q <= 1'b0;
            esel_q <= '0;
        end else if (wr_ctl) begin
            cont_q <= wdata[CTL_CONT];
            esel_q <= wdata[CTL_ES +: ES_W];
        end
    end

    // Status flags: hardware set beats write-zero clear; enables are plain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_fl <= 1'b0;
            end_fl <= 1'b0;
            ovf_ie <= 1'b0;
            end_ie <= 1'b0;
        end else begin
            ovf_fl <= ovf_set | (ovf_fl & ~(wr_st & ~wdata[SB_OVF]));
            end_fl <= end_set | (end_fl & ~(wr_st & ~wdata[SB_END]));
            if (wr_st) begin
                ovf_ie <= wdata[SB_OVF_IE];
                end_ie <= wdata[SB_END_IE];
            end
        end
    end

    // Result buffer: loaded only by the sequencer, never by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      buf_q <= '0;
        else if (buf_ld) buf_q <= cnt;
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[CTL_RUN]         = (state != ST_IDLE);
                rdata[CTL_CONT]        = cont_q;
                rdata[CTL_ES +: ES_W]  = esel_q;
            end
            A_STAT: begin
                rdata[SB_OVF]    = ovf_fl;
                rdata[SB_END]    = end_fl;
                rdata[SB_OVF_IE] = ovf_ie;
                rdata[SB_END_IE] = end_ie;
            end
            A_BUF:   rdata = buf_q;
            default: rdata = cnt;
        endcase
    end

    assign irq_ovf = ovf_fl & ovf_ie;
    assign irq_end = end_fl & end_ie;
endmodule

// File: rtl/pwc_timer.sv
// Top of the pulse width capture timer: edge qualifier, sequencer and
// register block. Assumes tick comes from an external prescaler and that
// meas_in is synchronized.
module pwc_timer
    import pwc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] rdata,
    input  logic          tick,
    input  logic          meas_in,
    output logic          irq_ovf,
    output logic          irq_end
);
    logic            start_ev, end_ev;
    logic            restart, stop, cont;
    logic [ES_W-1:0] esel;
    pwc_state_e      state;
    logic [CW-1:0]   cnt;
    logic            ovf_set, end_set, buf_ld;
    logic [CW-1:0]   buf_q;
    logic            ovf_fl, end_fl;

    pwc_edge u_edge (
        .clk(clk), .rst_n(rst_n), .meas_in(meas_in), .esel(esel),
        .start_ev(start_ev), .end_ev(end_ev)
    );

    pwc_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .start_ev(start_ev), .end_ev(end_ev),
        .restart(restart), .stop(stop), .cont(cont),
        .state_q(state), .cnt_q(cnt),
        .ovf_set(ovf_set), .end_set(end_set), .buf_ld(buf_ld)
    );

    pwc_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .state(state), .cnt(cnt),
        .ovf_set(ovf_set), .end_set(end_set), .buf_ld(buf_ld),
        .restart(restart), .stop(stop), .cont(cont), .esel(esel),
        .rdata(rdata), .buf_q(buf_q), .ovf_fl(ovf_fl), .end_fl(end_fl),
        .irq_ovf(irq_ovf), .irq_end(irq_end)
    );
endmodule

// File: rtl/pwc_timer_chk.sv
// Property checker for pwc_timer, attached by bind below.
module pwc_timer_chk
    import pwc_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          start_ev,
    input logic          end_ev,
    input logic          restart,
    input logic          stop,
    input logic          cont,
    input pwc_state_e    state,
    input logic [CW-1:0] cnt,
    input logic          end_set,
    input logic          buf_ld,
    input logic [CW-1:0] buf_q,
    input logic          ovf_fl,
    input logic          end_fl
);
    p_buf_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_ld |=> $stable(buf_q));

    p_buf_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_ld |=> (buf_q == $past(cnt)));

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        end_set |=> end_fl);

    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && tick && cnt == {CW{1'b1}} && !end_ev && !restart && !stop)
        |=> (ovf_fl && cnt == '0 && state == ST_COUNT));

    p_rearm_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !(cont && start_ev)) |=> (cnt == '0 && state == ST_WAIT));

    p_rearm_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && cont && start_ev) |=> (cnt == CW'(1) && state == ST_COUNT));

    p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !start_ev && !restart && !stop) |=> ($stable(cnt) && state == ST_WAIT));

    p_stop_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (state == ST_IDLE && cnt == $past(cnt)));
endmodule

bind pwc_timer pwc_timer_chk #(.CW(CW)) i_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .start_ev(start_ev), .end_ev(end_ev),
    .restart(restart), .stop(stop), .cont(cont),
    .state(state), .cnt(cnt), .end_set(end_set), .buf_ld(buf_ld),
    .buf_q(buf_q), .ovf_fl(ovf_fl), .end_fl(end_fl)
);

// File: tb/test_pwc_timer.sv
module test_pwc_timer;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [CW-1:0] wdata = '0;
    logic [CW-1:0] rdata;
    logic          tick = 1'b0;
    logic          meas = 1'b0;
    logic          irq_ovf, irq_end;

    int n_chk = 0;
    int n_fail = 0;
    logic [CW-1:0] v;
    logic [CW-1:0] prev_buf;

    always #5 clk = ~clk;

    pwc_timer #(.CW(CW)) i_pwc_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick(tick), .meas_in(meas),
        .irq_ovf(irq_ovf), .irq_end(irq_end)
    );

    // {esel[35:33], idle level[32], a[31:24], b[23:16], expected result[15:0]}
    localparam logic [35:0] VEC [10] = '{
        {3'd1, 1'b0, 8'd5, 8'd3, 16'd4},
        {3'd2, 1'b0, 8'd5, 8'd3, 16'd7},
        {3'd3, 1'b0, 8'd4, 8'd6, 16'd9},
        {3'd4, 1'b0, 8'd5, 8'd3, 16'd2},
        {3'd5, 1'b0, 8'd6, 8'd2, 16'd5},
        {3'd1, 1'b1, 8'd5, 8'd3, 16'd2},
        {3'd4, 1'b1, 8'd5, 8'd3, 16'd4},
        {3'd2, 1'b1, 8'd4, 8'd2, 16'd5},
        {3'd0, 1'b0, 8'd5, 8'd3, 16'd5},
        {3'd1, 1'b0, 8'd1, 8'd1, 16'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; write lands on the next rising edge.
    task automatic bus_wr(input logic [1:0] a, input logic [CW-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [CW-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            bus_rd(2'(i), v);
            chk("R1 reg", 32'(v), 32'd0);
        end
        chk("R1 irq", {30'd0, irq_ovf, irq_end}, 32'd0);

        // R3 R5: table of edge selections, single-shot
        for (int k = 0; k < 10; k++) begin
            bus_wr(2'd1, 16'h0000);
            meas = VEC[k][32];
            tick = 1'b1;
            repeat (3) @(negedge clk);
            bus_wr(2'd0, CW'({VEC[k][35:33], 1'b0, 1'b1}));
            meas = ~VEC[k][32];
            repeat (VEC[k][31:24]) @(negedge clk);
            meas = VEC[k][32];
            repeat (VEC[k][23:16]) @(negedge clk);
            meas = ~VEC[k][32];
            repeat (VEC[k][31:24]) @(negedge clk);
            meas = VEC[k][32];
            repeat (3) @(negedge clk);
            bus_rd(2'd2, v);
            chk("R3 R5 result", 32'(v), 32'(VEC[k][15:0]));
            bus_rd(2'd1, v);
            chk("R5 end flag", 32'(v[2]), 32'(VEC[k][35:33] != 3'd0));
            bus_rd(2'd0, v);
            chk("R5 run bit", 32'(v[0]), 32'(VEC[k][35:33] == 3'd0));
            chk("R8 irq_end gated", 32'(irq_end), 32'd0);
            @(negedge clk);
        end

        // R4 R2: counting only on ticks inside the window
        bus_wr(2'd0, 16'h0000);
        meas = 1'b0; tick = 1'b1;
        repeat (3) @(negedge clk);
        bus_wr(2'd0, 16'h0005);
        repeat (4) @(negedge clk);
        bus_rd(2'd3, v);
        chk("R4 hold while waiting", 32'(v), 32'd0);
        meas = 1'b1; tick = 1'b0;
        repeat (3) @(negedge clk);
        tick = 1'b1;
        repeat (4) @(negedge clk);
        bus_rd(2'd3, v);
        chk("R4 count", 32'(v), 32'd4);
        meas = 1'b0; tick = 1'b0;
        repeat (2) @(negedge clk);
        bus_rd(2'd2, v);
        chk("R4 result", 32'(v), 32'd4);
        bus_rd(2'd3, v);
        chk("R4 idle hold", 32'(v), 32'd4);
        bus_wr(2'd0, 16'h0005);
        bus_rd(2'd3, v);
        chk("R2 cleared", 32'(v), 32'd0);
        bus_rd(2'd0, v);
        chk("R2 run bit", 32'(v[0]), 32'd1);

        // R10: result buffer ignores writes
        bus_wr(2'd2, 16'h1234);
        bus_rd(2'd2, v);
        chk("R10 write ignored", 32'(v), 32'd4);

        // R9 R8: set beats clear in the same cycle
        bus_wr(2'd1, 16'h0040);
        meas = 1'b1;
        repeat (3) @(negedge clk);
        meas = 1'b0;
        bus_wr(2'd1, 16'h0040);
        bus_rd(2'd1, v);
        chk("R9 set wins", 32'(v[2]), 32'd1);
        chk("R8 irq_end", 32'(irq_end), 32'd1);
        bus_wr(2'd1, 16'h0040);
        bus_rd(2'd1, v);
        chk("R9 clear", 32'(v[2]), 32'd0);
        bus_wr(2'd1, 16'h0045);
        bus_rd(2'd1, v);
        chk("R9 write one no set", 32'(v & 16'h0005), 32'd0);
        chk("R8 irq_end low", 32'(irq_end), 32'd0);

        // R7 R13: counter wrap and stop
        bus_wr(2'd1, 16'h0010);
        meas = 1'b0;
        bus_wr(2'd0, 16'h0005);
        meas = 1'b1; tick = 1'b1;
        repeat (65539) @(negedge clk);
        bus_rd(2'd3, v);
        chk("R7 wrapped count", 32'(v), 32'd2);
        bus_rd(2'd1, v);
        chk("R7 wrap flag", 32'(v[0]), 32'd1);
        chk("R8 irq_ovf", 32'(irq_ovf), 32'd1);
        bus_rd(2'd0, v);
        chk("R7 still counting", 32'(v[0]), 32'd1);
        bus_wr(2'd1, 16'h0010);
        chk("R9 wrap flag cleared", 32'(irq_ovf), 32'd0);
        bus_wr(2'd0, 16'h0004);
        bus_rd(2'd3, prev_buf);
        repeat (5) @(negedge clk);
        bus_rd(2'd3, v);
        chk("R13 counter held", 32'(v), 32'(prev_buf));
        bus_rd(2'd0, v);
        chk("R13 idle", 32'(v[0]), 32'd0);

        // R11: rearm with start edge in repeat mode
        meas = 1'b0; tick = 1'b0;
        bus_wr(2'd0, 16'h0007);
        repeat (2) @(negedge clk);
        meas = 1'b1;
        bus_wr(2'd0, 16'h0007);
        bus_rd(2'd3, v);
        chk("R11 starts at one", 32'(v), 32'd1);
        tick = 1'b1;
        repeat (3) @(negedge clk);
        bus_rd(2'd3, v);
        chk("R11 counting", 32'(v), 32'd4);

        // R6: repeat-mode period measurement, back to back
        bus_wr(2'd0, 16'h0000);
        meas = 1'b0;
        bus_wr(2'd0, 16'h000B);
        repeat (2) @(negedge clk);
        meas = 1'b1; repeat (2) @(negedge clk);
        meas = 1'b0; repeat (3) @(negedge clk);
        meas = 1'b1; repeat (2) @(negedge clk);
        bus_rd(2'd2, v);
        chk("R6 first period", 32'(v), 32'd4);
        meas = 1'b0; repeat (5) @(negedge clk);
        meas = 1'b1; repeat (2) @(negedge clk);
        bus_rd(2'd2, v);
        chk("R6 second period", 32'(v), 32'd6);
        bus_rd(2'd0, v);
        chk("R6 still armed", 32'(v[0]), 32'd1);

        // R12: rearm with end edge, single-shot then repeat
        bus_wr(2'd0, 16'h0000);
        bus_wr(2'd1, 16'h0000);
        meas = 1'b0;
        bus_rd(2'd2, prev_buf);
        bus_wr(2'd0, 16'h0005);
        meas = 1'b1;
        repeat (5) @(negedge clk);
        meas = 1'b0;
        bus_wr(2'd0, 16'h0005);
        bus_rd(2'd1, v);
        chk("R12 single flag", 32'(v[2]), 32'd1);
        bus_rd(2'd2, v);
        chk("R12 single buffer kept", 32'(v), 32'(prev_buf));
        bus_rd(2'd3, v);
        chk("R12 single counter", 32'(v), 32'd0);
        bus_rd(2'd0, v);
        chk("R12 single waiting", 32'(v[0]), 32'd1);
        bus_wr(2'd1, 16'h0000);
        bus_wr(2'd0, 16'h0007);
        meas = 1'b1;
        repeat (5) @(negedge clk);
        meas = 1'b0;
        bus_wr(2'd0, 16'h0007);
        bus_rd(2'd1, v);
        chk("R12 repeat flag", 32'(v[2]), 32'd1);
        bus_rd(2'd2, v);
        chk("R12 repeat buffer", 32'(v), 32'd4);
        bus_rd(2'd3, v);
        chk("R12 repeat counter", 32'(v), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule